// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the peripheral end of a three-line serial control bus. A host moves a bus clock, a framing line and a data line; the target samples all three with its own system clock, rebuilds the frame, and either updates one of two 24-bit control registers or returns a 24-bit status word on the data line. The control registers drive the function being controlled. The status words come from that function.

A frame holds an 8-bit address followed by 24 data bits. Bits travel least significant first and are taken on rising bus-clock edges. The framing line is low for the first four address bits and high for the remaining address bits and for all data bits. The host ends a frame by pulling the framing line low and then returning it high. A write becomes visible when the framing line falls, and only if the frame was complete. For a read, the selected status word is captured in parallel on the ninth falling bus-clock edge. It is then shifted out, one bit per falling edge, while the block drives the data line.

Top module: `tws_target`

## Requirements
- R1: After reset both control registers hold zero, the data-line drive enable is low and the data output rests high.
- R2: Address bit 7 (the last address bit on the wire) set to 1 marks a read and cleared marks a write. Address bits 6..0 select the target: 7'h05 selects register A and 7'h0A selects register B. Every field is sent least significant bit first and sampled on a rising bus-clock edge.
- R3: A write frame of exactly 32 bits updates the selected control register when the framing line falls, and not before.
- R4: A write changes only the register it selects. A write to any other select value changes neither register. A read frame changes neither register.
- R5: A frame that ends with fewer than 32 bits changes no register.
- R6: A frame in which the framing line is high during one of the first four address bits changes no register, and the next correct frame is accepted.
- R7: In a read, the drive enable stays low through the address. On the ninth falling bus-clock edge the selected status word (A from `stat_a_i`, B from `stat_b_i`) is captured in parallel and bit 0 is driven. Each later falling edge drives the next bit. A change on the status input after the capture does not alter the bits sent.
- R8: A read with an unknown select value drives 24 zero bits.
- R9: The drive enable drops once the framing line falls at the end of a read.
- R10: A write frame with more than 32 bits changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all bus lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock from the host |
| bus_per_i | input | 1 | Framing line from the host |
| bus_dat_i | input | 1 | Serial data from the host |
| bus_dat_o | output | 1 | Serial read data toward the host, high when not driving |
| bus_dat_oe_o | output | 1 | Drive enable for the data line |
| stat_a_i | input | 24 | Status word returned for select A |
| stat_b_i | input | 24 | Status word returned for select B |
| ctrl_a_o | output | 24 | Control register A |
| ctrl_b_o | output | 24 | Control register B |

## Verification
The hardest case to reach from the pins is a frame that a framing-line edge breaks off in the middle. That edge restarts the bit count, so the rest of the frame is counted from zero, and the frame must still never commit. The bench reaches it by sending an address whose framing pattern goes high at bit 2 and then low at bit 3. It then sends a full set of data bits and checks that both registers keep their values. A clean write follows and must be accepted. The parallel-capture instant is tested by changing the status input right after the first read bit: the bits that follow must still come from the word held at the ninth falling edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

   // Index of each bus line inside the synchronized line vector
   localparam int LINE_CLK = 0;
   localparam int LINE_PER = 1;
   localparam int LINE_DAT = 2;
   localparam int N_LINES  = 3;

   // Decoded destination of a frame
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_A    = 2'd1,
      TGT_B    = 2'd2
   } tws_tgt_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int                STAGES  = 2,
   parameter int                LINES   = 3,
   parameter logic [LINES-1:0]  RST_LVL = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LINES-1:0] pin_i,
   output logic [LINES-1:0] lvl_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q <= {STAGES{RST_LVL[g]}};
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
         end
      end

      assign lvl_o[g] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/tws_edge.sv
module tws_edge #(
   parameter logic RST_LVL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= RST_LVL;
      end else begin
         prev_q <= lvl_i;
      end
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/tws_frame.sv
module tws_frame #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 24,
   parameter int PER_SWITCH = 4
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 clk_rise_i,
   input  logic                                 per_lvl_i,
   input  logic                                 per_rise_i,
   input  logic                                 per_fall_i,
   input  logic                                 dat_lvl_i,
   output logic [$clog2(ADDR_W+DATA_W+1)-1:0]   cnt_o,
   output logic [ADDR_W-1:0]                    addr_o,
   output logic [DATA_W-1:0]                    data_o,
   output logic                                 frame_ok_o
);

   localparam int FRAME_BITS = ADDR_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] FRAME_C  = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] SWITCH_C = CNT_W'(PER_SWITCH);

   logic [CNT_W-1:0]      cnt_q;
   logic [FRAME_BITS-1:0] sr_q;
   logic                  bad_q;
   logic                  frame_ok_q;
   logic                  want_hi;

   // Framing level expected while the current bit is sampled
   assign want_hi = (cnt_q >= SWITCH_C);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         sr_q       <= '0;
         bad_q      <= 1'b0;
         frame_ok_q <= 1'b0;
      end else begin
         frame_ok_q <= 1'b0;
         if (per_fall_i) begin
            // End of one frame and start of the next
            frame_ok_q <= (cnt_q == FRAME_C) && !bad_q;
            cnt_q      <= '0;
            bad_q      <= 1'b0;
         end else if (per_rise_i && (cnt_q != SWITCH_C)) begin
            // Rise anywhere but mid-address restarts the count
            cnt_q <= '0;
            bad_q <= 1'b0;
         end else if (clk_rise_i) begin
            if (cnt_q == FRAME_C) begin
               bad_q <= 1'b1;
            end else begin
               for (int i = 0; i < FRAME_BITS; i++) begin
                  if (cnt_q == CNT_W'(i)) begin
                     sr_q[i] <= dat_lvl_i;
                  end
               end
               cnt_q <= cnt_q + 1'b1;
               if (per_lvl_i != want_hi) begin
                  bad_q <= 1'b1;
               end
            end
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign addr_o     = sr_q[ADDR_W-1:0];
   assign data_o     = sr_q[FRAME_BITS-1:ADDR_W];
   assign frame_ok_o = frame_ok_q;

   // R3: a completed frame is only reported after a framing fall
   a_r3_ok_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ok_q |-> $past(per_fall_i));

   // R5: a completed frame had the full bit count
   a_r5_ok_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ok_q |-> $past(cnt_q == FRAME_C));

endmodule

// File: rtl/tws_regs.sv
module tws_regs
   import tws_pkg::*;
#(
   parameter int                ADDR_W  = 8,
   parameter int                DATA_W  = 24,
   parameter logic [ADDR_W-2:0] SEL_A   = 7'h05,
   parameter logic [ADDR_W-2:0] SEL_B   = 7'h0A,
   parameter logic [DATA_W-1:0] RST_A   = '0,
   parameter logic [DATA_W-1:0] RST_B   = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_ok_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] stat_a_i,
   input  logic [DATA_W-1:0] stat_b_i,
   output logic              rd_o,
   output logic [DATA_W-1:0] rd_word_o,
   output logic [DATA_W-1:0] ctrl_a_o,
   output logic [DATA_W-1:0] ctrl_b_o
);

   localparam int N_REG = 2;

   tws_tgt_e          tgt;
   logic [ADDR_W-2:0] sel;
   logic [DATA_W-1:0] ctrl_q [N_REG];
   logic [DATA_W-1:0] rst_val [N_REG];
   logic [N_REG-1:0]  hit;

   assign sel  = addr_i[ADDR_W-2:0];
   assign rd_o = addr_i[ADDR_W-1];

   always_comb begin
      if (sel == SEL_A) begin
         tgt = TGT_A;
      end else if (sel == SEL_B) begin
         tgt = TGT_B;
      end else begin
         tgt = TGT_NONE;
      end
   end

   always_comb begin
      unique case (tgt)
         TGT_A:   rd_word_o = stat_a_i;
         TGT_B:   rd_word_o = stat_b_i;
         default: rd_word_o = '0;
      endcase
   end

   assign hit[0]     = (tgt == TGT_A);
   assign hit[1]     = (tgt == TGT_B);
   assign rst_val[0] = RST_A;
   assign rst_val[1] = RST_B;

   for (genvar r = 0; r < N_REG; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ctrl_q[r] <= (r == 0) ? RST_A : RST_B;
         end else if (frame_ok_i && !rd_o && hit[r]) begin
            ctrl_q[r] <= data_i;
         end
      end

      // R4: a register moves only after a write frame that selects it
      a_r4_ctrl_only_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$stable(ctrl_q[r]) |-> $past(frame_ok_i && !addr_i[ADDR_W-1] && hit[r]));

      // R1: the reset value is the one the register leaves reset with
      a_r1_reset_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(rst_ni) |-> (ctrl_q[r] == rst_val[r]));
   end

   assign ctrl_a_o = ctrl_q[0];
   assign ctrl_b_o = ctrl_q[1];

endmodule

// File: rtl/tws_shout.sv
module tws_shout #(
   parameter int   ADDR_W   = 8,
   parameter int   DATA_W   = 24,
   parameter int   CNT_W    = 6,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clk_fall_i,
   input  logic              per_rise_i,
   input  logic              per_fall_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              dat_o,
   output logic              oe_o
);

   localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(ADDR_W);

   logic [DATA_W-1:0] sh_q;
   logic              oe_q;
   logic              load;

   // Ninth falling edge: address complete, first data bit begins
   assign load = clk_fall_i && (cnt_i == LOAD_C) && rd_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q <= '0;
         oe_q <= 1'b0;
      end else if (per_rise_i || per_fall_i) begin
         oe_q <= 1'b0;
      end else if (load) begin
         sh_q <= word_i;
         oe_q <= 1'b1;
      end else if (clk_fall_i && oe_q) begin
         sh_q <= {1'b0, sh_q[DATA_W-1:1]};
      end
   end

   assign dat_o = oe_q ? sh_q[0] : IDLE_LVL;
   assign oe_o  = oe_q;

   // R7: drive starts only on a bus-clock fall with the address complete
   a_r7_oe_on_ninth_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oe_q) |-> $past(clk_fall_i && (cnt_i == LOAD_C)));

   // R9: drive ends only on a framing edge
   a_r9_oe_ends_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(oe_q) |-> $past(per_rise_i || per_fall_i));

endmodule

// File: rtl/tws_target.sv
module tws_target
   import tws_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 24,
   parameter int PER_SWITCH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-2:0] SEL_A  = 7'h05,
   parameter logic [ADDR_W-2:0] SEL_B  = 7'h0A,
   parameter logic [DATA_W-1:0] RST_A  = '0,
   parameter logic [DATA_W-1:0] RST_B  = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_clk_i,
   input  logic              bus_per_i,
   input  logic              bus_dat_i,
   output logic              bus_dat_o,
   output logic              bus_dat_oe_o,
   input  logic [DATA_W-1:0] stat_a_i,
   input  logic [DATA_W-1:0] stat_b_i,
   output logic [DATA_W-1:0] ctrl_a_o,
   output logic [DATA_W-1:0] ctrl_b_o
);

   localparam int CNT_W = $clog2(ADDR_W + DATA_W + 1);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("tws_target: ADDR_W must leave room for a read flag and a select");
   end
   if ((PER_SWITCH < 1) || (PER_SWITCH >= ADDR_W)) begin : g_bad_switch
      $error("tws_target: PER_SWITCH must fall inside the address");
   end
   if (SEL_A == SEL_B) begin : g_bad_sel
      $error("tws_target: the two selects must differ");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("tws_target: DATA_W must be positive");
   end

   logic [N_LINES-1:0] pins;
   logic [N_LINES-1:0] lvl;
   logic               clk_rise, clk_fall;
   logic               per_rise, per_fall;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  addr;
   logic [DATA_W-1:0]  data;
   logic               frame_ok;
   logic               rd;
   logic [DATA_W-1:0]  rd_word;

   assign pins[LINE_CLK] = bus_clk_i;
   assign pins[LINE_PER] = bus_per_i;
   assign pins[LINE_DAT] = bus_dat_i;

   tws_sync #(
      .STAGES  (SYNC_STAGES),
      .LINES   (N_LINES),
      .RST_LVL ({N_LINES{1'b1}})
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins),
      .lvl_o  (lvl)
   );

   tws_edge #(.RST_LVL(1'b1)) u_clk_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[LINE_CLK]),
      .rise_o (clk_rise),
      .fall_o (clk_fall)
   );

   tws_edge #(.RST_LVL(1'b1)) u_per_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[LINE_PER]),
      .rise_o (per_rise),
      .fall_o (per_fall)
   );

   tws_frame #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PER_SWITCH (PER_SWITCH)
   ) u_frame (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clk_rise_i (clk_rise),
      .per_lvl_i  (lvl[LINE_PER]),
      .per_rise_i (per_rise),
      .per_fall_i (per_fall),
      .dat_lvl_i  (lvl[LINE_DAT]),
      .cnt_o      (cnt),
      .addr_o     (addr),
      .data_o     (data),
      .frame_ok_o (frame_ok)
   );

   tws_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEL_A  (SEL_A),
      .SEL_B  (SEL_B),
      .RST_A  (RST_A),
      .RST_B  (RST_B)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frame_ok_i (frame_ok),
      .addr_i     (addr),
      .data_i     (data),
      .stat_a_i   (stat_a_i),
      .stat_b_i   (stat_b_i),
      .rd_o       (rd),
      .rd_word_o  (rd_word),
      .ctrl_a_o   (ctrl_a_o),
      .ctrl_b_o   (ctrl_b_o)
   );

   tws_shout #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .IDLE_LVL (1'b1)
   ) u_shout (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clk_fall_i (clk_fall),
      .per_rise_i (per_rise),
      .per_fall_i (per_fall),
      .cnt_i      (cnt),
      .rd_i       (rd),
      .word_i     (rd_word),
      .dat_o      (bus_dat_o),
      .oe_o       (bus_dat_oe_o)
   );

endmodule

// File: tb/tws_target_test.sv
module tws_target_test;

   localparam int CLK_P    = 10;
   localparam int HOLD     = 6;
   localparam int WD_LIMIT = 150000;
   localparam int NV       = 8;

   typedef struct packed {
      logic        rd;
      logic [6:0]  sel;
      logic [23:0] word;
      logic [23:0] exp_a;
      logic [23:0] exp_b;
      logic [23:0] exp_rd;
   } vec_t;

   // Writes: word is the data. Reads: stat_a = word, stat_b = ~word.
   localparam vec_t VECS [NV] = '{
      '{1'b0, 7'h05, 24'h123456, 24'h123456, 24'h000000, 24'h000000},
      '{1'b0, 7'h0A, 24'hABCDEF, 24'h123456, 24'hABCDEF, 24'h000000},
      '{1'b0, 7'h33, 24'hFFFFFF, 24'h123456, 24'hABCDEF, 24'h000000},
      '{1'b1, 7'h05, 24'h5A5A5A, 24'h123456, 24'hABCDEF, 24'h5A5A5A},
      '{1'b1, 7'h0A, 24'h0F0F0F, 24'h123456, 24'hABCDEF, 24'hF0F0F0},
      '{1'b1, 7'h40, 24'h777777, 24'h123456, 24'hABCDEF, 24'h000000},
      '{1'b0, 7'h05, 24'hFFFFFF, 24'hFFFFFF, 24'hABCDEF, 24'h000000},
      '{1'b0, 7'h05, 24'h000001, 24'h000001, 24'hABCDEF, 24'h000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        bper = 1'b1;
   logic        bdat = 1'b1;
   logic [23:0] stat_a = '0;
   logic [23:0] stat_b = '0;
   logic        dat_o, dat_oe;
   logic [23:0] ctrl_a, ctrl_b;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   tws_target uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_clk_i    (bclk),
      .bus_per_i    (bper),
      .bus_dat_i    (bdat),
      .bus_dat_o    (dat_o),
      .bus_dat_oe_o (dat_oe),
      .stat_a_i     (stat_a),
      .stat_b_i     (stat_b),
      .ctrl_a_o     (ctrl_a),
      .ctrl_b_o     (ctrl_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b, input logic p);
      bper = p; bdat = b; bclk = 1'b0;
      step(HOLD);
      bclk = 1'b1;
      step(HOLD);
   endtask

   task automatic frame_open();
      bper = 1'b1; bclk = 1'b1; bdat = 1'b1;
      step(HOLD);
      bper = 1'b0;
      step(HOLD);
   endtask

   task automatic frame_addr(input logic [7:0] a, input logic [7:0] per_pat);
      for (int i = 0; i < 8; i++) put_bit(a[i], per_pat[i]);
   endtask

   task automatic frame_wdata(input logic [23:0] d, input int n);
      logic [31:0] dx;
      dx = {8'hFF, d};
      for (int i = 0; i < n; i++) put_bit(dx[i], 1'b1);
   endtask

   task automatic frame_rdata(input logic clobber, output logic [23:0] q, output logic oe_all);
      oe_all = 1'b1;
      q = '0;
      for (int i = 0; i < 24; i++) begin
         bper = 1'b1; bdat = 1'b1; bclk = 1'b0;
         step(HOLD);
         q[i] = dat_o;
         oe_all = oe_all & dat_oe;
         if (clobber && i == 0) stat_a = 24'h000000;
         bclk = 1'b1;
         step(HOLD);
      end
   endtask

   task automatic frame_close(input logic check_oe);
      bper = 1'b0;
      step(HOLD);
      if (check_oe) chk("R9 drive enable after framing fall", {31'd0, dat_oe}, 32'd0);
      bper = 1'b1;
      step(HOLD);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [23:0] d);
      frame_open();
      frame_addr(a, 8'hF0);
      frame_wdata(d, 24);
      frame_close(1'b0);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [23:0] q;
      logic        oe_all;

      step(4);
      // R1: reset state
      chk("R1 ctrl_a in reset", {8'd0, ctrl_a}, 32'd0);
      chk("R1 drive enable in reset", {31'd0, dat_oe}, 32'd0);
      rst_n = 1'b1;
      step(HOLD);
      chk("R1 ctrl_b after reset", {8'd0, ctrl_b}, 32'd0);
      chk("R1 idle data level", {31'd0, dat_o}, 32'd1);

      // Vector table: R2 bit order and address fields, R3/R4 writes, R7/R8 reads
      for (int v = 0; v < NV; v++) begin
         if (!VECS[v].rd) begin
            do_write({1'b0, VECS[v].sel}, VECS[v].word);
         end else begin
            stat_a = VECS[v].word;
            stat_b = ~VECS[v].word;
            frame_open();
            frame_addr({1'b1, VECS[v].sel}, 8'hF0);
            frame_rdata(1'b0, q, oe_all);
            frame_close(1'b1);
            chk("R7/R8 read word (R2 order)", {8'd0, q}, {8'd0, VECS[v].exp_rd});
            chk("R7 drive enable during read", {31'd0, oe_all}, 32'd1);
         end
         chk("R3/R4 ctrl_a after vector", {8'd0, ctrl_a}, {8'd0, VECS[v].exp_a});
         chk("R3/R4 ctrl_b after vector", {8'd0, ctrl_b}, {8'd0, VECS[v].exp_b});
      end

      // R3: no update before the framing fall, update after it
      frame_open();
      frame_addr(8'h05, 8'hF0);
      frame_wdata(24'h00AA55, 24);
      chk("R3 ctrl_a before framing fall", {8'd0, ctrl_a}, 32'h000001);
      bper = 1'b0;
      step(HOLD);
      chk("R3 ctrl_a after framing fall", {8'd0, ctrl_a}, 32'h00AA55);
      bper = 1'b1;
      step(HOLD);

      // R5: short frame
      frame_open();
      frame_addr(8'h0A, 8'hF0);
      frame_wdata(24'h111111, 20);
      frame_close(1'b0);
      chk("R5 ctrl_b after short frame", {8'd0, ctrl_b}, 32'hABCDEF);

      // R10: long frame
      frame_open();
      frame_addr(8'h0A, 8'hF0);
      frame_wdata(24'h222222, 25);
      frame_close(1'b0);
      chk("R10 ctrl_b after long frame", {8'd0, ctrl_b}, 32'hABCDEF);

      // R6: framing high during address bit 2, then a clean frame
      frame_open();
      frame_addr(8'h05, 8'hF4);
      frame_wdata(24'h444444, 24);
      frame_close(1'b0);
      chk("R6 ctrl_a after bad framing", {8'd0, ctrl_a}, 32'h00AA55);
      do_write(8'h05, 24'h333333);
      chk("R6 ctrl_a after recovery", {8'd0, ctrl_a}, 32'h333333);

      // R7: parallel capture at the ninth fall, drive off during address
      stat_a = 24'h3C3C3C;
      frame_open();
      frame_addr(8'h85, 8'hF0);
      chk("R7 drive enable through address", {31'd0, dat_oe}, 32'd0);
      frame_rdata(1'b1, q, oe_all);
      frame_close(1'b1);
      chk("R7 captured word kept", {8'd0, q}, 32'h3C3C3C);
      chk("R4 ctrl_a unchanged by read", {8'd0, ctrl_a}, 32'h333333);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule